// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This engine draws axis-aligned rectangles into a frame buffer of 16-bit pixels that lives in external memory. A host feeds it 32-bit command words over a valid/ready stream. Most words are parameter loads: destination start, source start, width, height and fill colour. A separate launch word then starts either a solid fill of the destination rectangle or a copy from the source rectangle into it. Every parameter is held until it is overwritten, so a repeated operation needs only a new launch word.

While an operation runs, the engine visits the rectangle row by row, left to right, through a single-word memory port. On that port a request stays up until `mem_ready`, and read data comes back later on `mem_rvalid`. The line pitch, in pixels, comes from a static configuration input. The command stream is back-pressured for the whole operation: `cmd_ready` stays low from the cycle after a launch until the last pixel write has been accepted. The memory side back-pressures the engine by holding `mem_ready` low, and the engine then keeps its request steady.

Top module: `blit2d_engine`

## Requirements
- R1: Each command word carries its opcode in bits [31:24] and its operand below. A word with any opcode other than 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x21 or 0x23 is accepted and has no effect.
- R2: Opcode 0x0C sets the destination start and opcode 0x0D sets the source start. Both are byte addresses taken from operand bits [23:0], with bit 0 forced to zero.
- R3: Opcode 0x0E sets the width and opcode 0x0F sets the height. Each is taken from operand bits [9:0] and means the pixel count minus one.
- R4: Opcode 0x0B sets a 16-bit colour from operand bits [15:0]. Opcode 0x23 writes that colour to every destination pixel in row-major order. Pixel x of a row is written at the row start plus 2·x.
- R5: After each row, the row start advances by 2·`pitch_px` bytes, modulo 2^24. This applies to the source row as well as the destination row.
- R6: Opcode 0x21 copies the rectangle. For each pixel in row-major order, the engine reads the source pixel and then writes the returned value to the destination at the same offset.
- R7: Parameters keep their values across operations and across ignored words.
- R8: `exec_status[1]` (busy) rises in the cycle after a launch word is accepted and falls when the last write is accepted. `cmd_ready` is low whenever the engine is busy.
- R9: `done` is high for exactly one cycle, the cycle after the last write is accepted. `irq` pulses together with `done` only if bit 1 of the launch word was set.
- R10: `exec_status[0]` holds bit 0 (end of list) of the launch word of the most recently completed operation. It is 0 after reset.
- R11: A memory request (`mem_valid`) keeps its address, write flag and write data stable until `mem_ready`. A read request completes only when data returns on `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Engine can take a command word |
| cmd_data | input | 32 | Command word |
| pitch_px | input | PITCH_W | Line pitch in pixels |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the pixel |
| mem_wdata | output | 16 | Pixel to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| exec_status | output | 2 | Bit 1 busy, bit 0 last end-of-list flag |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A wrong counter or row base shows up at the very next memory request as a wrong address. The scoreboard compares every request, so such a fault is reported within a cycle or two of the slip. A wrong pixel latch or colour register shows up in the write data of the first write it affects. A broken end-of-rectangle test shows up in one of two ways: a surplus request the scoreboard does not expect, or a `done` that never comes and trips the watchdog. Launches with the interrupt bit set and clear tell a swapped or stuck interrupt flag apart, at the `done` cycle of the operation.

// File: rtl/blit2d_pkg.sv
package blit2d_pkg;
  localparam int ADDR_W = 24;
  localparam int DIM_W  = 10;
  localparam int PIX_W  = 16;
  localparam int CMD_W  = 32;

  localparam logic [7:0] OP_COLOR = 8'h0B;
  localparam logic [7:0] OP_DST   = 8'h0C;
  localparam logic [7:0] OP_SRC   = 8'h0D;
  localparam logic [7:0] OP_WID   = 8'h0E;
  localparam logic [7:0] OP_HGT   = 8'h0F;
  localparam logic [7:0] OP_COPY  = 8'h21;
  localparam logic [7:0] OP_FILL  = 8'h23;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_RWAIT, ST_WR} blit_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [DIM_W-1:0]  wid;
    logic [DIM_W-1:0]  hgt;
    logic [PIX_W-1:0]  color;
  } blit_params_t;
endpackage

// File: rtl/blit2d_param_regs.sv
module blit2d_param_regs
  import blit2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CMD_W-1:0] cmd,
  output blit_params_t     prm
);
  logic [7:0] opc;
  assign opc = cmd[CMD_W-1:CMD_W-8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prm <= '0;
    end else if (load) begin
      case (opc)
        OP_DST:   prm.dst   <= {cmd[ADDR_W-1:1], 1'b0};
        OP_SRC:   prm.src   <= {cmd[ADDR_W-1:1], 1'b0};
        OP_WID:   prm.wid   <= cmd[DIM_W-1:0];
        OP_HGT:   prm.hgt   <= cmd[DIM_W-1:0];
        OP_COLOR: prm.color <= cmd[PIX_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/blit2d_addr_gen.sv
module blit2d_addr_gen
  import blit2d_pkg::*;
#(
  parameter int PITCH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               step,
  input  logic [ADDR_W-1:0]  dst_base,
  input  logic [ADDR_W-1:0]  src_base,
  input  logic [DIM_W-1:0]   wid_m1,
  input  logic [DIM_W-1:0]   hgt_m1,
  input  logic [PITCH_W-1:0] pitch_px,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [ADDR_W-1:0]  src_addr,
  output logic               last_px
);
  logic [DIM_W-1:0]  x_q, y_q;
  logic [ADDR_W-1:0] dst_row_q, src_row_q;
  logic [ADDR_W-1:0] row_step, x_off;
  logic              row_end;

  assign row_step = ADDR_W'({pitch_px, 1'b0});
  assign x_off    = ADDR_W'({x_q, 1'b0});
  assign row_end  = (x_q == wid_m1);
  assign last_px  = row_end && (y_q == hgt_m1);
  assign dst_addr = dst_row_q + x_off;
  assign src_addr = src_row_q + x_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q       <= '0;
      y_q       <= '0;
      dst_row_q <= '0;
      src_row_q <= '0;
    end else if (start) begin
      x_q       <= '0;
      y_q       <= '0;
      dst_row_q <= dst_base;
      src_row_q <= src_base;
    end else if (step) begin
      if (row_end) begin
        x_q       <= '0;
        y_q       <= y_q + 1'b1;
        dst_row_q <= dst_row_q + row_step;
        src_row_q <= src_row_q + row_step;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blit2d_engine.sv
module blit2d_engine
  import blit2d_pkg::*;
#(
  parameter int PITCH_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_data,
  input  logic [PITCH_W-1:0] pitch_px,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [PIX_W-1:0]   mem_wdata,
  input  logic               mem_rvalid,
  input  logic [PIX_W-1:0]   mem_rdata,
  output logic [1:0]         exec_status,
  output logic               done,
  output logic               irq
);
  blit_params_t      prm;
  blit_state_e       state_q;
  logic              cmd_fire, is_go, mem_fire, wr_fire, last_px;
  logic              copy_q, irq_req_q, end_req_q, end_flag_q, done_q, irq_q;
  logic [PIX_W-1:0]  pix_q;
  logic [ADDR_W-1:0] dst_addr, src_addr;
  logic [7:0]        opc;

  assign opc       = cmd_data[CMD_W-1:CMD_W-8];
  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign is_go     = cmd_fire && (opc == OP_FILL || opc == OP_COPY);
  assign mem_valid = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_fire  = mem_valid && mem_ready;
  assign wr_fire   = mem_fire && mem_we;
  assign mem_addr  = (state_q == ST_RD) ? src_addr : dst_addr;
  assign mem_wdata = copy_q ? pix_q : prm.color;

  assign exec_status = {state_q != ST_IDLE, end_flag_q};
  assign done        = done_q;
  assign irq         = irq_q;

  blit2d_param_regs u_params (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cmd_fire),
    .cmd  (cmd_data),
    .prm  (prm)
  );

  blit2d_addr_gen #(.PITCH_W(PITCH_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (is_go),
    .step    (wr_fire),
    .dst_base(prm.dst),
    .src_base(prm.src),
    .wid_m1  (prm.wid),
    .hgt_m1  (prm.hgt),
    .pitch_px(pitch_px),
    .dst_addr(dst_addr),
    .src_addr(src_addr),
    .last_px (last_px)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      copy_q     <= 1'b0;
      irq_req_q  <= 1'b0;
      end_req_q  <= 1'b0;
      end_flag_q <= 1'b0;
      done_q     <= 1'b0;
      irq_q      <= 1'b0;
      pix_q      <= '0;
    end else begin
      done_q <= wr_fire && last_px;
      irq_q  <= wr_fire && last_px && irq_req_q;
      case (state_q)
        ST_IDLE: if (is_go) begin
          copy_q    <= (opc == OP_COPY);
          end_req_q <= cmd_data[0];
          irq_req_q <= cmd_data[1];
          state_q   <= (opc == OP_COPY) ? ST_RD : ST_WR;
        end
        ST_RD: if (mem_fire) state_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid) begin
          pix_q   <= mem_rdata;
          state_q <= ST_WR;
        end
        ST_WR: if (mem_fire) begin
          if (last_px) begin
            end_flag_q <= end_req_q;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= copy_q ? ST_RD : ST_WR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blit2d_checker.sv
module blit2d_checker
  import blit2d_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CMD_W-1:0]  cmd_data,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PIX_W-1:0]  mem_wdata,
  input logic [1:0]        exec_status,
  input logic              done,
  input logic              irq
);
  p_busy_blocks_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_status[1] |-> !cmd_ready);

  p_go_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_data[31:24] == OP_FILL || cmd_data[31:24] == OP_COPY))
      |=> exec_status[1]);

  p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

  p_req_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> exec_status[1]);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !exec_status[1]);

  p_irq_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

bind blit2d_engine blit2d_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_data   (cmd_data),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .exec_status(exec_status),
  .done       (done),
  .irq        (irq)
);

// File: tb/blit2d_engine_tb_top.sv
module blit2d_engine_tb_top;
  localparam int PW = 12;

  typedef struct {
    logic        we;
    logic [23:0] addr;
    logic [15:0] data;
  } xact_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [31:0]   cmd_data = '0;
  logic [PW-1:0] pitch_px = PW'(8);
  logic          mem_valid, mem_we, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [23:0]   mem_addr;
  logic [15:0]   mem_wdata, mem_rdata = '0;
  logic [1:0]    exec_status;
  logic          done, irq;

  int tests = 0, fails = 0, done_cnt = 0, irq_cnt = 0, cyc = 0;
  bit wd_hit = 1'b0;
  xact_t exp_q[$];

  always #2.5 clk = ~clk;

  blit2d_engine #(.PITCH_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .pitch_px(pitch_px), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .exec_status(exec_status), .done(done), .irq(irq)
  );

  function automatic logic [15:0] src_pix(input logic [23:0] a);
    return a[16:1] ^ 16'hC3A5;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // memory model and scoreboard monitor
  initial begin
    bit pend = 1'b0;
    logic [23:0] pend_a = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rvalid = pend;
      mem_rdata  = pend ? src_pix(pend_a) : 16'h0;
      pend = 1'b0;
      mem_ready = (cyc % 3) != 0;
      if (done) done_cnt++;
      if (irq) irq_cnt++;
      #1;
      if (rst_n && mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          check("R4 surplus request", {7'b0, mem_we, mem_addr}, 32'hFFFFFFFF);
        end else begin
          xact_t e;
          e = exp_q.pop_front();
          check(e.we ? "R4/R6 write kind" : "R6 read kind", {31'b0, mem_we}, {31'b0, e.we});
          check("R5 address", {8'b0, mem_addr}, {8'b0, e.addr});
          if (e.we) check("R4/R6 write data", {16'b0, mem_wdata}, {16'b0, e.data});
        end
        if (!mem_we) begin
          pend = 1'b1;
          pend_a = mem_addr;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 100000 && !wd_hit) wd_hit = 1'b1;
    end
  end

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready && !wd_hit) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic exp_fill(input logic [23:0] dst, input int w, input int h,
                          input int pitch, input logic [15:0] col);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        xact_t e;
        e.we = 1'b1;
        e.addr = 24'(dst + 24'(y * pitch * 2) + 24'(x * 2));
        e.data = col;
        exp_q.push_back(e);
      end
  endtask

  task automatic exp_copy(input logic [23:0] src, input logic [23:0] dst, input int w,
                          input int h, input int pitch);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        xact_t r, e;
        r.we = 1'b0;
        r.addr = 24'(src + 24'(y * pitch * 2) + 24'(x * 2));
        r.data = '0;
        e.we = 1'b1;
        e.addr = 24'(dst + 24'(y * pitch * 2) + 24'(x * 2));
        e.data = src_pix(r.addr);
        exp_q.push_back(r);
        exp_q.push_back(e);
      end
  endtask

  task automatic launch(input logic [31:0] go, input bit want_irq, input string tag);
    int d0 = done_cnt, i0 = irq_cnt;
    send(go);
    @(negedge clk);
    #2;
    check({tag, " R8 busy after launch"}, {31'b0, exec_status[1]}, 32'd1);
    check({tag, " R8 cmd_ready low"}, {31'b0, cmd_ready}, 32'd0);
    while (done_cnt == d0 && !wd_hit) @(negedge clk);
    #2;
    check({tag, " R9 one done"}, done_cnt - d0, 32'd1);
    check({tag, " R9 irq"}, irq_cnt - i0, want_irq ? 32'd1 : 32'd0);
    check({tag, " R4 all pixels issued"}, exp_q.size(), 32'd0);
    check({tag, " R10 end flag"}, {31'b0, exec_status[0]}, {31'b0, go[0]});
    check({tag, " R8 idle"}, {31'b0, exec_status[1]}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("reset R8 busy", {31'b0, exec_status[1]}, 32'd0);
    check("reset R10 flag", {31'b0, exec_status[0]}, 32'd0);
    check("reset R11 mem_valid", {31'b0, mem_valid}, 32'd0);
    check("reset R9 done", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R8 ready after reset", {31'b0, cmd_ready}, 32'd1);

    // R2 bit 0 cleared, R3 count minus one, R4 fill
    send(32'h0C000101);
    send(32'h0E000002);
    send(32'h0F000001);
    send(32'h0B00ABCD);
    exp_fill(24'h000100, 3, 2, 8, 16'hABCD);
    launch(32'h23000003, 1'b1, "fill1");

    // R1 unknown opcodes ignored, R7 params retained
    send(32'h55FFFFFF);
    send(32'h0A00FFFF);
    exp_fill(24'h000100, 3, 2, 8, 16'hABCD);
    launch(32'h23000000, 1'b0, "fill2");

    // R3 masking of high operand bits, R2/R5 24-bit wrap of row start
    send(32'h0EFFFC00);
    send(32'h0F000002);
    send(32'h0CFFFFFF);
    send(32'h0B001234);
    exp_fill(24'hFFFFFE, 1, 3, 8, 16'h1234);
    launch(32'h23000002, 1'b1, "fill3");

    // R6 copy with a different pitch (R5)
    pitch_px = PW'(5);
    send(32'h0D000400);
    send(32'h0C000800);
    send(32'h0E000001);
    send(32'h0F000001);
    exp_copy(24'h000400, 24'h000800, 2, 2, 5);
    launch(32'h21000001, 1'b0, "copy1");

    // R7 second copy with only a launch word
    exp_copy(24'h000400, 24'h000800, 2, 2, 5);
    launch(32'h21000002, 1'b1, "copy2");

    if (wd_hit) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule